// File: doc/BRIEF.md
# Serial Byte Receiver with Ready/Acknowledge Handshake

This block takes an asynchronous serial line carrying 8N1 frames and turns each frame into a parallel byte. The line is idle high. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts `2*(HALF_CNT+1)` clock cycles. The receiver does not rely on a free-running bit clock. When it is idle, a falling edge on the synchronized line raises a one-cycle alignment pulse, and that pulse restarts the internal bit-timing divider. Every bit is then sampled a fixed distance into its period, measured from the edge.

Once the stop bit is sampled high, the byte is presented with a ready level. That level stays high, and the byte stays frozen, until the consumer raises an acknowledge. While a byte waits, anything on the line is ignored. After the acknowledge the receiver goes idle and waits for the next start edge. A consumer that keeps the acknowledge high all the time sees a one-cycle ready pulse for every frame.

Top module: `uart_rx_handshake`

## Requirements
- R1: After reset `byteReady` is 0 and `rxByte` is 8'h00.
- R2: A frame made of a start bit (0), eight data bits sent least significant bit first, and a stop bit (1), with each bit held for `2*(HALF_CNT+1)` clocks, appears on `rxByte` with the first data bit in bit 0.
- R3: `byteReady` stays 0 until the stop bit has been sampled high, and is 1 by the end of the stop bit.
- R4: While `byteReady` is 1 and `ackIn` is 0, `byteReady` stays 1 and `rxByte` does not change, even when a further frame arrives on the line.
- R5: When `ackIn` is 1 while `byteReady` is 1, `byteReady` drops on the next clock and the receiver accepts the following frame.
- R6: `ackIn` has no effect while `byteReady` is 0. With `ackIn` held at 1, each frame produces exactly one cycle of `byteReady` with the correct byte.
- R7: A low pulse on an idle line shorter than half a bit period starts no reception: `byteReady` stays 0 and `rxByte` is unchanged.
- R8: Each start edge seen while idle produces exactly one alignment pulse, so frames separated by idle gaps of any length, including gaps that are not whole bit periods, are received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Serial line, idle high, asynchronous to clk |
| ackIn | input | 1 | Consumer acknowledge level |
| rxByte | output | 8 | Last received byte |
| byteReady | output | 1 | High while a received byte waits for acknowledge |

## Verification
The hardest case to reach from the ports is an alignment pulse landing at an arbitrary point of a free-running divider. A falling edge must re-phase timing that would otherwise sample in the wrong place. The stimulus reaches this by putting an idle gap of a different odd length before each table frame, so every frame starts at a new divider phase. A second hard case is a frame arriving while a byte still waits. The bench sends one deliberately without acknowledging, then confirms that the held byte survives and that the receiver recovers. A short idle glitch and a run with the acknowledge held high cover the remaining two paths out of the idle and stop states.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;
    logic clearIdx;
    logic storeBit;
    logic incIdx;
    logic setReady;
    logic clrReady;
  } rxCtl_t;

endpackage

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int HALF_CNT    = 5208,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  rxCtl_t            ctl,
  output logic              startTick,
  output logic              bitTick,
  output logic              lineHigh,
  output logic              lastBit,
  output logic              byteReady,
  output logic [DATA_W-1:0] rxByte,
  output logic              syncPulse
);

  localparam int CW = $clog2(HALF_CNT + 1);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(HALF_CNT);
  localparam logic [IW-1:0] IDX_END = IW'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lineSync;
  logic                   lineDly;
  logic                   fallEdge;
  logic [CW-1:0]          divCnt;
  logic                   divPhase;
  logic                   locked;
  logic [IW-1:0]          bitIdx;

  // metastability chain, resets to idle level
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], serialIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= serialIn;
      end
    end
  endgenerate

  assign lineSync = syncReg[SYNC_STAGES-1];
  assign lineHigh = lineSync;
  assign fallEdge = lineDly & ~lineSync;

  // edge delay and alignment pulse (high during reset)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineDly   <= 1'b1;
      syncPulse <= 1'b1;
    end else begin
      lineDly   <= lineSync;
      syncPulse <= ctl.idle & fallEdge;
    end
  end

  // re-phasable half-bit divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      divPhase <= 1'b0;
    end else if (syncPulse) begin
      divCnt   <= CNT_END;
      divPhase <= 1'b0;
    end else if (divCnt == CNT_END) begin
      divCnt   <= '0;
      divPhase <= ~divPhase;
    end else begin
      divCnt   <= divCnt + 1'b1;
    end
  end

  // sample strobe: high-to-low transition of the divider phase
  assign bitTick = divPhase & (divCnt == CNT_END) & ~syncPulse;

  // timing is trusted for a start only after a fresh alignment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        locked <= 1'b0;
    else if (syncPulse)               locked <= 1'b1;
    else if (fallEdge | ctl.clearIdx) locked <= 1'b0;
  end

  assign startTick = bitTick & locked & ~fallEdge & ~lineSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitIdx <= '0;
    else if (ctl.clearIdx) bitIdx <= '0;
    else if (ctl.incIdx)   bitIdx <= bitIdx + 1'b1;
  end

  assign lastBit = (bitIdx == IDX_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxByte <= '0;
    else if (ctl.storeBit) rxByte[bitIdx] <= lineSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             byteReady <= 1'b0;
    else if (ctl.setReady) byteReady <= 1'b1;
    else if (ctl.clrReady) byteReady <= 1'b0;
  end

endmodule

// File: rtl/uart_rx_control.sv
module uart_rx_control
  import uart_rx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startTick,
  input  logic   bitTick,
  input  logic   lineHigh,
  input  logic   lastBit,
  input  logic   byteReady,
  input  logic   ackIn,
  output rxCtl_t ctl
);

  rxState_t state;
  rxState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    ctl.idle  = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (startTick) begin
          ctl.clearIdx = 1'b1;
          stateNext    = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bitTick) begin
          ctl.storeBit = 1'b1;
          if (lastBit) stateNext  = ST_STOP;
          else         ctl.incIdx = 1'b1;
        end
      end
      ST_STOP: begin
        if (!byteReady && bitTick && lineHigh) begin
          ctl.setReady = 1'b1;
        end else if (ackIn && byteReady) begin
          ctl.clrReady = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/uart_rx_handshake.sv
module uart_rx_handshake
  import uart_rx_pkg::*;
#(
  parameter int HALF_CNT = 5208
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialIn,
  input  logic       ackIn,
  output logic [7:0] rxByte,
  output logic       byteReady
);

  rxCtl_t ctl;
  logic   startTick;
  logic   bitTick;
  logic   lineHigh;
  logic   lastBit;
  logic   syncPulse;

  uart_rx_datapath #(
    .HALF_CNT    (HALF_CNT),
    .DATA_W      (8),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .ctl       (ctl),
    .startTick (startTick),
    .bitTick   (bitTick),
    .lineHigh  (lineHigh),
    .lastBit   (lastBit),
    .byteReady (byteReady),
    .rxByte    (rxByte),
    .syncPulse (syncPulse)
  );

  uart_rx_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startTick (startTick),
    .bitTick   (bitTick),
    .lineHigh  (lineHigh),
    .lastBit   (lastBit),
    .byteReady (byteReady),
    .ackIn     (ackIn),
    .ctl       (ctl)
  );

endmodule

// File: rtl/uart_rx_handshake_chk.sv
module uart_rx_handshake_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ackIn,
  input logic       byteReady,
  input logic [7:0] rxByte,
  input logic       syncPulse
);

  // R8
  sync_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse);

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteReady && !ackIn) |=> byteReady);

  // R4
  byte_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteReady && !ackIn) |=> $stable(rxByte));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteReady && ackIn) |=> !byteReady);

endmodule

bind uart_rx_handshake uart_rx_handshake_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ackIn     (ackIn),
  .byteReady (byteReady),
  .rxByte    (rxByte),
  .syncPulse (syncPulse)
);

// File: tb/uart_rx_handshake_bench.sv
`timescale 1ns/1ps
module uart_rx_handshake_bench;

  localparam int HALF = 15;
  localparam int BIT  = 2 * (HALF + 1);
  localparam int NVEC = 6;
  // {byte, idle gap in clocks before the frame}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h24, 8'd3},  {8'h00, 8'd17}, {8'hFF, 8'd41},
    {8'hA5, 8'd7},  {8'h5A, 8'd29}, {8'h81, 8'd53}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b1;
  logic       ackIn = 1'b0;
  logic [7:0] rxByte;
  logic       byteReady;

  int testCnt = 0;
  int failCnt = 0;
  bit monOn = 1'b0;
  int monCnt = 0;
  logic [7:0] monByte [2];

  always #4 clk = ~clk;

  uart_rx_handshake #(.HALF_CNT(HALF)) u_uart_rx_handshake (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .ackIn     (ackIn),
    .rxByte    (rxByte),
    .byteReady (byteReady)
  );

  always @(negedge clk) begin
    if (monOn && byteReady) begin
      if (monCnt < 2) monByte[monCnt] = rxByte;
      monCnt = monCnt + 1;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleFor(input int n);
    serialIn = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // start bit plus eight data bits, stop bit left to caller
  task automatic sendHead(input logic [7:0] b);
    serialIn = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serialIn = b[i];
      repeat (BIT) @(negedge clk);
    end
  endtask

  task automatic sendStop();
    serialIn = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic ackPulse();
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {7'd0, byteReady}, 8'h00);
    check("R1 byte after reset", rxByte, 8'h00);
    idleFor(BIT + 5);

    // table walk: R2, R3, R4, R5, R8
    for (int v = 0; v < NVEC; v++) begin
      idleFor(int'(VEC[v][7:0]));
      sendHead(VEC[v][15:8]);
      check("R3 no ready before stop", {7'd0, byteReady}, 8'h00);
      sendStop();
      check("R3 ready after stop", {7'd0, byteReady}, 8'h01);
      check("R2 R8 received byte", rxByte, VEC[v][15:8]);
      idleFor(20);
      check("R4 ready held without ack", {7'd0, byteReady}, 8'h01);
      ackPulse();
      check("R5 ready cleared by ack", {7'd0, byteReady}, 8'h00);
    end

    // R4: frame arriving while a byte waits is ignored
    idleFor(11);
    sendHead(8'h66);
    sendStop();
    check("R2 byte before ignored frame", rxByte, 8'h66);
    idleFor(9);
    sendHead(8'h99);
    sendStop();
    check("R4 ready kept during extra frame", {7'd0, byteReady}, 8'h01);
    check("R4 byte kept during extra frame", rxByte, 8'h66);
    ackPulse();
    check("R5 ready cleared after extra frame", {7'd0, byteReady}, 8'h00);

    // R7: short glitch on idle line
    idleFor(BIT + 7);
    serialIn = 1'b0;
    repeat (4) @(negedge clk);
    idleFor(3 * BIT);
    check("R7 no ready after glitch", {7'd0, byteReady}, 8'h00);
    check("R7 byte unchanged after glitch", rxByte, 8'h66);
    idleFor(13);
    sendHead(8'h42);
    sendStop();
    check("R5 R7 frame after glitch", rxByte, 8'h42);
    ackPulse();

    // R6: ack held high, back-to-back frames
    idleFor(BIT);
    ackIn = 1'b1;
    idleFor(BIT);
    check("R6 ack with ready low keeps ready low", {7'd0, byteReady}, 8'h00);
    monOn = 1'b1;
    sendHead(8'h3C);
    sendStop();
    sendHead(8'hC3);
    sendStop();
    idleFor(BIT);
    monOn = 1'b0;
    ackIn = 1'b0;
    check("R6 one ready cycle per frame", 8'(monCnt), 8'd2);
    check("R6 first byte with held ack", monByte[0], 8'h3C);
    check("R6 second byte with held ack", monByte[1], 8'hC3);
    check("R6 ready low at end", {7'd0, byteReady}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule